// File: doc/BRIEF.md
# Constrained Random Instruction Stream Generator

This block produces a stream of random but always-legal instructions, one for every clock cycle in which `en` is high. A 32-bit pseudo-random generator supplies the draw for each instruction. That draw picks one of eight instruction classes, two source indices, a destination candidate and an immediate. Per-class rules turn the draw into operands that are legal by construction, so nothing is ever rejected or redrawn.

The only state carried from one instruction to the next is a 32-entry written-register set. It starts as `{r0}`. Each emitted destination joins it, and every source register is picked from it. As a result, a source is always a register that reset or an earlier instruction has defined.

A build-time option splits the source scan into two registered stages. One stage reduces the index; the other picks the set member. This adds one cycle of latency and leaves both the throughput and the instruction sequence unchanged.

Top module: `instr_stream_gen`

## Requirements
- R1: After a reset, `out_valid` is low until an instruction is issued, and the live set holds only r0. The first instruction after reset therefore has both `out_rs1` and `out_rs2` equal to 0.
- R2: With `SPLIT_SCAN`=0, `out_valid` is high exactly one cycle after each cycle in which `en` was high. A cycle with `en` low emits nothing and does not advance the generator.
- R3: The generator is a 32-bit shift register. On each issue it shifts left and feeds `s[31]^s[21]^s[1]^s[0]` into bit 0. During reset it loads `seed_in`, with a zero seed replaced by 1. The class is `s[2:0]`: 0 ALU-register, 1 ALU-immediate, 2 load, 3 store, 4 branch, 5 upper-immediate, 6 jump, 7 vector.
- R4: The source indices are `ia = s[7:3]` and `ib = s[12:8]`. Each source register is the member of the live set whose rank, counted from the lowest register, equals the index modulo the live-set population.
- R5: Every emitted source register is a member of the live set as it stood when the instruction was issued.
- R6: For a class that writes, the destination comes from `s[17:13]`. Non-vector classes map 0 to 1. The vector class clears bit 0 and maps a result of 0 to 2. A written destination is therefore never r0, and a vector destination is always even.
- R7: Store and branch write no destination: `out_rd` is 0 and the live set is unchanged. `out_rs1` is 0 for upper-immediate and jump. `out_rs2` is 0 for ALU-immediate, load, upper-immediate and jump.
- R8: `out_imm` is `s[31:18]` for the ALU-immediate, load, store, branch, upper-immediate and jump classes, and 0 for ALU-register and vector.
- R9: A destination joins the live set in the cycle its instruction is issued. The sources of the next issued instruction already see it.
- R10: With `SPLIT_SCAN`=1, the emitted sequence is identical to that of `SPLIT_SCAN`=0, and `out_valid` is high exactly two cycles after each enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Issue one instruction this cycle |
| seed_in | input | 32 | Generator seed, loaded during reset |
| out_valid | output | 1 | An instruction is present on the outputs |
| out_class | output | 3 | Instruction class code (R3) |
| out_rs1 | output | 5 | First source register |
| out_rs2 | output | 5 | Second source register |
| out_rd | output | 5 | Destination register, 0 when none |
| out_imm | output | 14 | Immediate value, 0 when unused |

## Verification
Two functions land in the same cycle when instructions are issued back to back. Instruction n writes its destination into the live set at the same edge where instruction n+1 draws its sources from that set. In the split build, instruction n+1 instead captures its snapshot at that edge. Long runs with `en` held high provoke this collision, most sharply just after reset while the set is small and each new member shifts the modulo ranking. Runs with `en` randomly gapped provoke the same collision across idle cycles. The scoreboard's model updates its live set right after each issue. Any off-by-one-instruction error therefore shows up as a wrong source register in both builds.

// File: rtl/isg_pkg.sv
package isg_pkg;
  localparam int unsigned NREG = 32;
  localparam int unsigned REGW = $clog2(NREG);
  localparam int unsigned CNTW = REGW + 1;
  localparam int unsigned CLSW = 3;
  localparam int unsigned IMMW = 14;

  typedef logic [NREG-1:0] regset_t;
  typedef logic [REGW-1:0] regidx_t;
  typedef logic [CNTW-1:0] regcnt_t;

  typedef enum logic [CLSW-1:0] {
    CLS_ALU_R  = 3'd0,
    CLS_ALU_I  = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_BRANCH = 3'd4,
    CLS_UPPER  = 3'd5,
    CLS_JUMP   = 3'd6,
    CLS_VEC    = 3'd7
  } iclass_e;

  typedef struct packed {
    iclass_e           cls;
    regidx_t           ia;
    regidx_t           ib;
    regidx_t           rd;
    logic [IMMW-1:0]   imm;
  } draw_t;

  typedef struct packed {
    iclass_e           cls;
    regidx_t           rs1;
    regidx_t           rs2;
    regidx_t           rd;
    logic [IMMW-1:0]   imm;
  } instr_t;

  function automatic logic reads_a(iclass_e c);
    return !(c inside {CLS_UPPER, CLS_JUMP});
  endfunction

  function automatic logic reads_b(iclass_e c);
    return c inside {CLS_ALU_R, CLS_STORE, CLS_BRANCH, CLS_VEC};
  endfunction

  function automatic logic writes_rd(iclass_e c);
    return !(c inside {CLS_STORE, CLS_BRANCH});
  endfunction

  function automatic logic has_imm(iclass_e c);
    return !(c inside {CLS_ALU_R, CLS_VEC});
  endfunction

  // Population of a register set.
  function automatic regcnt_t pop_count(regset_t s);
    regcnt_t n;
    n = '0;
    for (int r = 0; r < NREG; r++) n = n + regcnt_t'(s[r]);
    return n;
  endfunction

  // Raw draw folded into [0, pop).
  function automatic regcnt_t fold_index(regidx_t raw, regcnt_t pop);
    if (pop == '0) return '0;
    return regcnt_t'({1'b0, raw} % pop);
  endfunction

  // Register holding rank k among the members of s, lowest first.
  function automatic regidx_t nth_member(regset_t s, regcnt_t k);
    regidx_t res;
    regcnt_t seen;
    res  = '0;
    seen = '0;
    for (int r = 0; r < NREG; r++) begin
      if (s[r]) begin
        if (seen == k) res = regidx_t'(r);
        seen = seen + 1'b1;
      end
    end
    return res;
  endfunction

  // Per-class destination legality mapping.
  function automatic regidx_t legal_dest(iclass_e c, regidx_t d);
    regidx_t v;
    if (c == CLS_VEC) begin
      v = {d[REGW-1:1], 1'b0};
      return (v == '0) ? regidx_t'(2) : v;
    end
    return (d == '0) ? regidx_t'(1) : d;
  endfunction
endpackage

// File: rtl/isg_lfsr.sv
module isg_lfsr #(
  parameter int unsigned W    = 32,
  parameter logic [W-1:0] TAPS = 'h8020_0003
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);
  logic [W-1:0] seed_fix;
  logic         fb;

  assign seed_fix = (seed == '0) ? {{(W-1){1'b0}}, 1'b1} : seed;
  assign fb       = ^(state & TAPS);

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= seed_fix;
    else if (step) state <= {state[W-2:0], fb};
  end

  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !step) |=> $stable(state)); // R2

  AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && step) |=> (state[W-1:1] == $past(state[W-2:0]))); // R3
endmodule

// File: rtl/isg_draw_decode.sv
module isg_draw_decode
  import isg_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] state,
  output draw_t        draw
);
  localparam int unsigned P_IA  = CLSW;
  localparam int unsigned P_IB  = P_IA + REGW;
  localparam int unsigned P_RD  = P_IB + REGW;
  localparam int unsigned P_IMM = P_RD + REGW;

  iclass_e cls;
  regidx_t d_raw;

  always_comb begin
    cls       = iclass_e'(state[CLSW-1:0]);
    d_raw     = state[P_RD +: REGW];
    draw.cls  = cls;
    draw.ia   = state[P_IA +: REGW];
    draw.ib   = state[P_IB +: REGW];
    draw.rd   = writes_rd(cls) ? legal_dest(cls, d_raw) : '0;
    draw.imm  = has_imm(cls) ? state[P_IMM +: IMMW] : '0;
  end
endmodule

// File: rtl/isg_live_set.sv
module isg_live_set
  import isg_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  regidx_t wr_idx,
  output regset_t live
);
  always_ff @(posedge clk) begin
    if (!rst_n)     live <= regset_t'(1);
    else if (wr_en) live <= live | (regset_t'(1) << wr_idx);
  end

  AST_LIVE_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((live & $past(live)) == $past(live))); // R9

  AST_LIVE_ONE_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones(live ^ $past(live)) <= 1)); // R9

  AST_LIVE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !wr_en) |=> $stable(live)); // R7
endmodule

// File: rtl/isg_src_select.sv
module isg_src_select
  import isg_pkg::*;
#(
  parameter bit SPLIT = 1'b0
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  draw_t   draw,
  input  regset_t live,
  output logic    out_valid,
  output instr_t  out_ins
);
  regcnt_t pop_now;
  assign pop_now = pop_count(live);

  if (SPLIT) begin : g_split
    logic            v_s1;
    regset_t         live_s1;
    iclass_e         cls_s1;
    regcnt_t         ka_s1;
    regcnt_t         kb_s1;
    regidx_t         rd_s1;
    logic [IMMW-1:0] imm_s1;

    // Stage 1: snapshot the set and reduce both indices.
    always_ff @(posedge clk) begin
      if (!rst_n) v_s1 <= 1'b0;
      else begin
        v_s1 <= in_valid;
        if (in_valid) begin
          live_s1 <= live;
          cls_s1  <= draw.cls;
          ka_s1   <= fold_index(draw.ia, pop_now);
          kb_s1   <= fold_index(draw.ib, pop_now);
          rd_s1   <= draw.rd;
          imm_s1  <= draw.imm;
        end
      end
    end

    // Stage 2: pick the ranked members.
    always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else begin
        out_valid <= v_s1;
        if (v_s1) begin
          out_ins.cls <= cls_s1;
          out_ins.rs1 <= reads_a(cls_s1) ? nth_member(live_s1, ka_s1) : '0;
          out_ins.rs2 <= reads_b(cls_s1) ? nth_member(live_s1, kb_s1) : '0;
          out_ins.rd  <= rd_s1;
          out_ins.imm <= imm_s1;
        end
      end
    end

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      v_s1 |-> ((ka_s1 < pop_count(live_s1)) && (kb_s1 < pop_count(live_s1)))); // R4

    AST_SNAP_HAS_R0: assert property (@(posedge clk) disable iff (!rst_n)
      v_s1 |-> live_s1[0]); // R1
  end else begin : g_flat
    always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else begin
        out_valid <= in_valid;
        if (in_valid) begin
          out_ins.cls <= draw.cls;
          out_ins.rs1 <= reads_a(draw.cls) ?
                         nth_member(live, fold_index(draw.ia, pop_now)) : '0;
          out_ins.rs2 <= reads_b(draw.cls) ?
                         nth_member(live, fold_index(draw.ib, pop_now)) : '0;
          out_ins.rd  <= draw.rd;
          out_ins.imm <= draw.imm;
        end
      end
    end
  end
endmodule

// File: rtl/instr_stream_gen.sv
module instr_stream_gen
  import isg_pkg::*;
#(
  parameter int unsigned       LFSR_W     = 32,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 'h8020_0003,
  parameter bit                SPLIT_SCAN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [LFSR_W-1:0] seed_in,
  output logic              out_valid,
  output logic [CLSW-1:0]   out_class,
  output logic [REGW-1:0]   out_rs1,
  output logic [REGW-1:0]   out_rs2,
  output logic [REGW-1:0]   out_rd,
  output logic [IMMW-1:0]   out_imm
);
  logic [LFSR_W-1:0] gen_state;
  draw_t             draw;
  regset_t           live;
  logic              live_wr;
  instr_t            ins;
  logic              ins_v;

  isg_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(en), .seed(seed_in), .state(gen_state)
  );

  isg_draw_decode #(.W(LFSR_W)) u_decode (
    .state(gen_state), .draw(draw)
  );

  // Named event: this issue adds its destination to the live set.
  assign live_wr = en && writes_rd(draw.cls);

  isg_live_set u_live (
    .clk(clk), .rst_n(rst_n), .wr_en(live_wr), .wr_idx(draw.rd), .live(live)
  );

  isg_src_select #(.SPLIT(SPLIT_SCAN)) u_src (
    .clk(clk), .rst_n(rst_n), .in_valid(en), .draw(draw), .live(live),
    .out_valid(ins_v), .out_ins(ins)
  );

  assign out_valid = ins_v;
  assign out_class = ins.cls;
  assign out_rs1   = ins.rs1;
  assign out_rs2   = ins.rs2;
  assign out_rd    = ins.rd;
  assign out_imm   = ins.imm;

  AST_SRC_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (live[out_rs1] && live[out_rs2])); // R5

  AST_RD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && writes_rd(ins.cls)) |-> (out_rd != '0)); // R6

  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ins.cls == CLS_VEC) |-> !out_rd[0]); // R6

  AST_NO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !writes_rd(ins.cls)) |-> (out_rd == '0)); // R7

  AST_UNUSED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !reads_a(ins.cls)) |-> (out_rs1 == '0 && out_rs2 == '0)); // R7

  AST_UNUSED_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !has_imm(ins.cls)) |-> (out_imm == '0)); // R8
endmodule

// File: tb/tb_instr_stream_gen.sv
`timescale 1ns/1ps
module tb_instr_stream_gen;
  typedef struct {
    logic [2:0]  cls;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [4:0]  rd;
    logic [13:0] imm;
    logic [31:0] live;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [31:0] seed = 32'h0;
  always #2.5 clk = ~clk;

  logic        v0, v1;
  logic [2:0]  c0, c1;
  logic [4:0]  a0, a1, b0, b1, d0, d1;
  logic [13:0] i0, i1;

  instr_stream_gen #(.SPLIT_SCAN(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .seed_in(seed), .out_valid(v0),
    .out_class(c0), .out_rs1(a0), .out_rs2(b0), .out_rd(d0), .out_imm(i0));

  instr_stream_gen #(.SPLIT_SCAN(1'b1)) dut_split (
    .clk(clk), .rst_n(rst_n), .en(en), .seed_in(seed), .out_valid(v1),
    .out_class(c1), .out_rs1(a1), .out_rs2(b1), .out_rd(d1), .out_imm(i1));

  int n_chk = 0, n_fail = 0;
  item_t q0[$], q1[$];
  logic first0, first1, mon_on = 1'b0, done = 1'b0;
  logic en_d1, en_d2;
  logic [31:0] m_state, m_live;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int rank_pick(logic [31:0] s, int k);
    for (int i = 0; i < 32; i++) if (s[i]) begin
      if (k == 0) return i;
      k--;
    end
    return 0;
  endfunction

  function automatic int reduce(int raw, int n);
    while (raw >= n) raw -= n;
    return raw;
  endfunction

  // Expected instruction from the current model state (R3, R4, R6, R7, R8).
  function automatic item_t predict();
    item_t e;
    int pc, d;
    bit ra, rb, wr, im;
    e.cls = m_state[2:0];
    case (e.cls)
      3'd0: begin ra = 1; rb = 1; wr = 1; im = 0; end
      3'd1, 3'd2: begin ra = 1; rb = 0; wr = 1; im = 1; end
      3'd3, 3'd4: begin ra = 1; rb = 1; wr = 0; im = 1; end
      3'd5, 3'd6: begin ra = 0; rb = 0; wr = 1; im = 1; end
      default: begin ra = 1; rb = 1; wr = 1; im = 0; end
    endcase
    pc = $countones(m_live);
    e.rs1 = ra ? 5'(rank_pick(m_live, reduce(int'(m_state[7:3]), pc))) : 5'd0;
    e.rs2 = rb ? 5'(rank_pick(m_live, reduce(int'(m_state[12:8]), pc))) : 5'd0;
    d = int'(m_state[17:13]);
    if (e.cls == 3'd7) begin
      d = d - (d % 2);
      if (d == 0) d = 2;
    end else if (d == 0) d = 1;
    e.rd = wr ? 5'(d) : 5'd0;
    e.imm = im ? m_state[31:18] : 14'd0;
    e.live = m_live;
    return e;
  endfunction

  task automatic drive(input logic e);
    item_t it;
    @(negedge clk);
    en = e;
    if (e) begin
      it = predict();
      q0.push_back(it);
      q1.push_back(it);
      // R9: destination joins the live set before the next draw.
      if (it.rd != 5'd0) m_live[it.rd] = 1'b1;
      m_state = {m_state[30:0], m_state[31] ^ m_state[21] ^ m_state[1] ^ m_state[0]};
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin en_d1 <= 1'b0; en_d2 <= 1'b0; end
    else begin en_d1 <= en; en_d2 <= en_d1; end
  end

  task automatic watch(input string who, input string pace_req, input logic v,
                       input logic exp_v, input logic [2:0] c, input logic [4:0] a,
                       input logic [4:0] b, input logic [4:0] d, input logic [13:0] i,
                       ref item_t q[$], ref logic first);
    item_t e;
    check(v === exp_v, pace_req, {who, " valid pacing"}, 32'(v), 32'(exp_v));
    if (v === 1'b1) begin
      if (q.size() == 0) begin
        check(1'b0, pace_req, {who, " unexpected instruction"}, 1, 0);
      end else begin
        e = q.pop_front();
        check(c == e.cls, "R3", {who, " class"}, 32'(c), 32'(e.cls));
        check(a == e.rs1, "R4/R9", {who, " rs1"}, 32'(a), 32'(e.rs1));
        check(b == e.rs2, "R4/R9", {who, " rs2"}, 32'(b), 32'(e.rs2));
        check(e.live[a] && e.live[b], "R5", {who, " source liveness"}, e.live, {a, 3'b0, b});
        check(d == e.rd, (e.cls == 3'd3 || e.cls == 3'd4) ? "R7" : "R6",
              {who, " rd"}, 32'(d), 32'(e.rd));
        check(i == e.imm, "R8", {who, " imm"}, 32'(i), 32'(e.imm));
        if (first) begin
          check(a == 5'd0 && b == 5'd0, "R1", {who, " first sources"}, {a, b}, 0);
          first = 1'b0;
        end
      end
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      watch("flat", "R2", v0, en_d1, c0, a0, b0, d0, i0, q0, first0);
      watch("split", "R10", v1, en_d2, c1, a1, b1, d1, i1, q1, first1);
    end
  end

  task automatic do_reset(input logic [31:0] s);
    @(negedge clk);
    mon_on = 1'b0;
    en = 1'b0;
    rst_n = 1'b0;
    seed = s;
    repeat (3) @(negedge clk);
    // R1: outputs idle while reset is held.
    check(v0 == 1'b0 && v1 == 1'b0, "R1", "valid in reset", {v0, v1}, 0);
    q0.delete();
    q1.delete();
    m_state = (s == 32'h0) ? 32'h1 : s;  // R3 zero seed
    m_live = 32'h1;
    first0 = 1'b1;
    first1 = 1'b1;
    rst_n = 1'b1;
    mon_on = 1'b1;
  endtask

  task automatic drain();
    repeat (4) drive(1'b0);
    check(q0.size() == 0 && q1.size() == 0, "R2", "queues drained",
          q0.size() + q1.size(), 0);
  endtask

  initial begin
    do_reset(32'hACE1_2345);
    drive(1'b0);
    repeat (200) drive(1'b1);
    drain();
    repeat (400) drive(1'($urandom_range(0, 1)));
    drain();
    do_reset(32'h0);
    repeat (150) drive(1'b1);
    drain();
    do_reset(32'hFFFF_FFFF);
    repeat (3) begin
      repeat (20) drive(1'b1);
      repeat (3) drive(1'b0);
    end
    repeat (100) drive(1'($urandom_range(0, 3) != 0));
    drain();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule